// File: doc/BRIEF.md
# Sequential Combination Lock Controller

This block is a clocked Moore state machine that unlocks only after three entered values arrive in the right order. Each stored code value is supplied on its own input. A one-cycle strobe marks each freshly entered value. On every strobe the entered value is compared with the stored code for the current step. A match moves the machine one step forward. A mismatch sends it to a fault state, and only reset can leave that state.

The outputs depend on the state alone. A 2-bit select names the stored code that the next value is compared against. A single flag reports whether the lock is open. The comparator inside the block uses this same select. The surrounding logic can use the select to see how far an entry has progressed. Debouncing, entry of the code values and driving the actuator all belong to the surrounding logic.

Top module: `combo_lock_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the machine enters step one. At that point `code_sel` is 0 and `lock_open` is 0.
- R2: A clock edge with `key_strobe` low leaves `code_sel` and `lock_open` unchanged, whatever `key_val` holds.
- R3: A strobe whose `key_val` equals `code_1st` while `code_sel` is 0 sets `code_sel` to 1. A strobe whose value equals `code_2nd` while `code_sel` is 1 sets `code_sel` to 2.
- R4: A strobe whose `key_val` differs from the selected code, in any of the three steps (`code_sel` 0, 1 or 2), enters the fault state. The fault state shows `code_sel` = 3 and `lock_open` = 0.
- R5: A strobe whose `key_val` equals `code_3rd` while `code_sel` is 2 enters the open state. The open state shows `lock_open` = 1 and `code_sel` = 3.
- R6: `lock_open` is 1 only in the open state. It is 0 in all three steps and in the fault state.
- R7: The fault state holds against every later strobe, including strobes carrying the correct code values.
- R8: The open state holds against every later strobe, including mismatching values.
- R9: Reset returns the machine to step one from both the open state and the fault state.
- R10: Each clock edge with `key_strobe` high counts as one separate entry. A strobe held high for two edges therefore evaluates two values, one at each edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| key_strobe | input | 1 | High for one cycle per newly entered value |
| key_val | input | 4 | Entered value |
| code_1st | input | 4 | Stored code value for step one |
| code_2nd | input | 4 | Stored code value for step two |
| code_3rd | input | 4 | Stored code value for step three |
| code_sel | output | 2 | Code under comparison: 0, 1, 2 for the steps, 3 in the open or fault state |
| lock_open | output | 1 | 1 when the lock is open |

## Verification
Both outputs come straight from the state register. Each one therefore changes on the rising edge that samples a strobe and is settled for the rest of that cycle. The bench drives `key_strobe` and `key_val` at a falling edge and drops the strobe at the next falling edge. It reads the outputs at that second falling edge, which is half a period after the one rising edge that evaluated the entry. Idle and hold checks wait several full cycles before sampling, so an unwanted change has time to appear.

// File: rtl/lock_pkg.sv
package lock_pkg;

    localparam int DIGIT_W = 4;
    localparam int NCODES  = 3;
    localparam int SEL_W   = $clog2(NCODES + 1);

    localparam logic [SEL_W-1:0] SEL_NONE = SEL_W'(NCODES);

    typedef enum logic [2:0] {
        ST_STEP1 = 3'd0,
        ST_STEP2 = 3'd1,
        ST_STEP3 = 3'd2,
        ST_OPEN  = 3'd3,
        ST_FAULT = 3'd4
    } lock_state_t;

    // Moore output: which stored code the next entry must match.
    function automatic logic [SEL_W-1:0] sel_of(input lock_state_t st);
        case (st)
            ST_STEP1: sel_of = SEL_W'(0);
            ST_STEP2: sel_of = SEL_W'(1);
            ST_STEP3: sel_of = SEL_W'(2);
            default:  sel_of = SEL_NONE;
        endcase
    endfunction

    function automatic logic open_of(input lock_state_t st);
        open_of = (st == ST_OPEN);
    endfunction

endpackage

// File: rtl/code_match.sv
module code_match
    import lock_pkg::*;
#(
    parameter int W = DIGIT_W,
    parameter int N = NCODES
) (
    input  logic [N-1:0][W-1:0] codes,
    input  logic [SEL_W-1:0]    sel,
    input  logic [W-1:0]        key,
    output logic                equal
);

    logic [N-1:0] hit;

    // One comparator slice per stored code; at most one slice is selected.
    for (genvar i = 0; i < N; i++) begin : g_slice
        assign hit[i] = (sel == SEL_W'(i)) && (key == codes[i]);
    end

    assign equal = |hit;

endmodule

// File: rtl/lock_seq.sv
module lock_seq
    import lock_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic             equal,
    output logic [SEL_W-1:0] code_sel,
    output logic             lock_open
);

    lock_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_STEP1: if (strobe) state_d = equal ? ST_STEP2 : ST_FAULT;
            ST_STEP2: if (strobe) state_d = equal ? ST_STEP3 : ST_FAULT;
            ST_STEP3: if (strobe) state_d = equal ? ST_OPEN  : ST_FAULT;
            ST_OPEN:  state_d = ST_OPEN;
            ST_FAULT: state_d = ST_FAULT;
            // Unused encodings fall into the fault state, never toward open.
            default:  state_d = ST_FAULT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_STEP1;
        else     state_q <= state_d;
    end

    assign code_sel  = sel_of(state_q);
    assign lock_open = open_of(state_q);

    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (code_sel == '0 && !lock_open));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> ($stable(code_sel) && $stable(lock_open)));

    p_advance_r3: assert property (@(posedge clk) disable iff (rst)
        (strobe && equal && code_sel == SEL_W'(0)) |=> (code_sel == SEL_W'(1)));

    p_mismatch_r4: assert property (@(posedge clk) disable iff (rst)
        (strobe && !equal && code_sel != SEL_NONE) |=> (code_sel == SEL_NONE && !lock_open));

    p_open_entry_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_open) |-> ($past(strobe) && $past(equal) && $past(code_sel) == SEL_W'(2)));

    p_closed_steps_r6: assert property (@(posedge clk) disable iff (rst)
        (code_sel != SEL_NONE) |-> !lock_open);

    p_fault_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (code_sel == SEL_NONE && !lock_open) |=> (code_sel == SEL_NONE && !lock_open));

    p_open_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        lock_open |=> lock_open);

endmodule

// File: rtl/combo_lock_ctrl.sv
module combo_lock_ctrl
    import lock_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               key_strobe,
    input  logic [DIGIT_W-1:0] key_val,
    input  logic [DIGIT_W-1:0] code_1st,
    input  logic [DIGIT_W-1:0] code_2nd,
    input  logic [DIGIT_W-1:0] code_3rd,
    output logic [SEL_W-1:0]   code_sel,
    output logic               lock_open
);

    logic [NCODES-1:0][DIGIT_W-1:0] codes;
    logic                           equal;

    assign codes = {code_3rd, code_2nd, code_1st};

    code_match #(.W(DIGIT_W), .N(NCODES)) u_match (
        .codes (codes),
        .sel   (code_sel),
        .key   (key_val),
        .equal (equal)
    );

    lock_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .strobe    (key_strobe),
        .equal     (equal),
        .code_sel  (code_sel),
        .lock_open (lock_open)
    );

endmodule

// File: tb/combo_lock_ctrl_test.sv
`timescale 1ns/100ps
module combo_lock_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_strobe = 1'b0;
    logic [3:0] key_val = 4'h0;
    logic [3:0] code_1st = 4'h3;
    logic [3:0] code_2nd = 4'h9;
    logic [3:0] code_3rd = 4'hC;
    logic [1:0] code_sel;
    logic       lock_open;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    combo_lock_ctrl uut (
        .clk(clk), .rst(rst), .key_strobe(key_strobe), .key_val(key_val),
        .code_1st(code_1st), .code_2nd(code_2nd), .code_3rd(code_3rd),
        .code_sel(code_sel), .lock_open(lock_open)
    );

    task automatic expect_out(input string req, input logic [1:0] esel, input logic eopen);
        total++;
        if (code_sel !== esel || lock_open !== eopen) begin
            bad++;
            $display("FAIL %s: sel=%0d open=%0d expected sel=%0d open=%0d",
                     req, code_sel, lock_open, esel, eopen);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; key_strobe = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // One entry: strobe high across exactly one rising edge.
    task automatic press(input logic [3:0] v);
        @(negedge clk); key_strobe = 1'b1; key_val = v;
        @(negedge clk); key_strobe = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        expect_out("R1 after reset", 2'd0, 1'b0);
    endtask

    task automatic t_idle();
        do_reset();
        key_val = code_1st;
        repeat (5) @(negedge clk);
        expect_out("R2 idle at step one", 2'd0, 1'b0);
        press(code_1st);
        key_val = code_2nd;
        repeat (4) @(negedge clk);
        expect_out("R2 idle at step two", 2'd1, 1'b0);
    endtask

    task automatic t_open_path();
        do_reset();
        press(code_1st);
        expect_out("R3 step one to two", 2'd1, 1'b0);
        press(code_2nd);
        expect_out("R3 step two to three", 2'd2, 1'b0);
        expect_out("R6 closed at step three", 2'd2, 1'b0);
        press(code_3rd);
        expect_out("R5 opened", 2'd3, 1'b1);
    endtask

    task automatic t_mismatch(input int step);
        do_reset();
        if (step >= 2) press(code_1st);
        if (step >= 3) press(code_2nd);
        press(4'h0);
        expect_out($sformatf("R4 mismatch at step %0d", step), 2'd3, 1'b0);
    endtask

    task automatic t_fault_sticky();
        do_reset();
        press(4'h7);
        press(code_1st);
        press(code_2nd);
        press(code_3rd);
        expect_out("R7 fault holds after correct codes", 2'd3, 1'b0);
        do_reset();
        expect_out("R9 reset leaves fault", 2'd0, 1'b0);
    endtask

    task automatic t_open_sticky();
        do_reset();
        press(code_1st); press(code_2nd); press(code_3rd);
        press(4'h1);
        press(code_1st);
        repeat (3) @(negedge clk);
        expect_out("R8 open holds after entries", 2'd3, 1'b1);
        do_reset();
        expect_out("R9 reset leaves open", 2'd0, 1'b0);
    endtask

    task automatic t_held_strobe();
        do_reset();
        @(negedge clk); key_strobe = 1'b1; key_val = code_1st;
        @(negedge clk); key_val = code_2nd;
        @(negedge clk); key_strobe = 1'b0;
        expect_out("R10 two edges give two entries", 2'd2, 1'b0);
        do_reset();
        @(negedge clk); key_strobe = 1'b1; key_val = code_1st;
        @(negedge clk);
        @(negedge clk); key_strobe = 1'b0;
        expect_out("R10 repeated value checked against code two", 2'd3, 1'b0);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_open_path();
        for (int s = 1; s <= 3; s++) t_mismatch(s);
        t_fault_sticky();
        t_open_sticky();
        t_held_strobe();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule